// File: doc/BRIEF.md
# Horizontal Sync Timing Generator for a Dot-Clocked LCD Panel

This block produces the horizontal sync pulse for a flat panel driven one dot per clock. Software programs a 16-bit sync register with two fields: the sync pulse length and the point in the line where the pulse begins. Both fields count 8-dot characters and are stored as the count minus one. An internal dot counter sweeps each line. Two identical sync outputs, a line clock and an Hsync, go high across the programmed window of dots.

The line length and the visible width come in as inputs, also in characters minus one. The block compares the active register fields with these inputs on every cycle. When a setting could not work on the panel, it raises an error flag and holds both sync outputs low. A register write is held in a shadow copy and only takes effect when the next line begins, so a pulse that has already started always runs to its full length.

Top module: `lcd_hsync_gen`

## Requirements
- R1: After reset the register reads 0x0050, which is width field 0 and position field 0x50. Both sync outputs are low while reset is held.
- R2: The width field sits in register bits 15:12 and the position field in bits 7:0. Bits 11:8 always read 0, whatever value was written to them. A read returns the most recently written value.
- R3: Let P be the active position field, W the active width field, and number the dots of a line from 1 at line start. Sync is high on every dot from (P+1)*8 up to and including (P+1)*8+(W+1)*8-1, and low on all other dots. The block takes one dot per clock.
- R4: With the reset setting, a line total of 99 and a display width of 79, sync is high on dots 648 through 655 and low on dots 647 and 656.
- R5: The line clock output equals the Hsync output on every cycle.
- R6: Let T be the line-total input. The error flag is high whenever T < P+W+1.
- R7: Let D be the display-width input. The error flag is high whenever P < D+1. When neither R6 nor R7 applies, the error flag is low.
- R8: While the error flag is high, both sync outputs are low.
- R9: A line holds (T+1)*8 dots. A register write changes the sync window only from the next line start. A pulse that is running when the write occurs finishes with its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock; one dot per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write value |
| regRdData | output | 16 | Register read value |
| lineTotal | input | 8 | Characters per line minus one |
| dispWidth | input | 8 | Visible characters per line minus one |
| lineClk | output | 1 | Line clock sync output |
| hsync | output | 1 | Horizontal sync output |
| cfgError | output | 1 | Active setting breaks a timing constraint |

## Verification
The bench sweeps every width value against four positions on a short 21-character line. The positions are one below the visible edge, exactly at it, mid-line, and the last position that still fits. This sweep separates correct window edges from off-by-one or off-by-eight faults and lands on both error boundaries at equality. A full-size line at the reset setting pins the absolute pulse location. A write made in the middle of a pulse tells deferred loading apart from immediate loading, because the old pulse must finish and the new window must appear on the following line. A write of all ones shows that the reserved bits read back as zero.

// File: rtl/lcd_hsync_pkg.sv
package lcd_hsync_pkg;

  // Strobes issued by the control each dot, consumed by the datapath.
  typedef struct packed {
    logic lineWrap;   // last dot of the line: restart count, load shadow
    logic syncSet;    // the next dot is the first dot of the pulse
    logic syncClr;    // the next dot is past the pulse, or the line restarts
  } hsync_strobe_t;

endpackage

// File: rtl/lcd_hsync_dp.sv
module lcd_hsync_dp
  import lcd_hsync_pkg::*;
#(
  parameter int WID_W = 4,
  parameter int POS_W = 8,
  parameter int REG_W = 16,
  parameter int DOT_W = 13,
  parameter logic [WID_W-1:0] RST_WID = '0,
  parameter logic [POS_W-1:0] RST_POS = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  hsync_strobe_t    strobe,
  output logic [REG_W-1:0] rdData,
  output logic [WID_W-1:0] actWid,
  output logic [POS_W-1:0] actPos,
  output logic [DOT_W-1:0] dotCnt,
  output logic             syncActive
);

  localparam int RSV_W = REG_W - WID_W - POS_W;
  localparam logic [REG_W-1:0] FIELD_MASK = {{WID_W{1'b1}}, {RSV_W{1'b0}}, {POS_W{1'b1}}};
  localparam logic [REG_W-1:0] RESET_VAL  = {RST_WID, {RSV_W{1'b0}}, RST_POS};

  logic [REG_W-1:0] shadowReg;
  logic [REG_W-1:0] activeReg;

  // Writes land in the shadow copy; the reserved bits never store anything.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowReg <= RESET_VAL;
    end else if (wrEn) begin
      shadowReg <= wrData & FIELD_MASK;
    end
  end

  // The active copy changes only at a line boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeReg <= RESET_VAL;
    end else if (strobe.lineWrap) begin
      activeReg <= shadowReg;
    end
  end

  // Dot counter, 0-based within the line.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dotCnt <= '0;
    end else if (strobe.lineWrap) begin
      dotCnt <= '0;
    end else begin
      dotCnt <= dotCnt + DOT_W'(1);
    end
  end

  // Pulse state, aligned with the dot counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncActive <= 1'b0;
    end else if (strobe.syncClr) begin
      syncActive <= 1'b0;
    end else if (strobe.syncSet) begin
      syncActive <= 1'b1;
    end
  end

  assign rdData = shadowReg;
  assign actWid = activeReg[REG_W-1 -: WID_W];
  assign actPos = activeReg[POS_W-1:0];

endmodule

// File: rtl/lcd_hsync_ctl.sv
module lcd_hsync_ctl
  import lcd_hsync_pkg::*;
#(
  parameter int WID_W     = 4,
  parameter int POS_W     = 8,
  parameter int CNT_W     = 8,
  parameter int CHAR_LOG2 = 3,
  parameter int DOT_W     = 13
) (
  input  logic [DOT_W-1:0] dotCnt,
  input  logic [WID_W-1:0] actWid,
  input  logic [POS_W-1:0] actPos,
  input  logic [CNT_W-1:0] lineTotal,
  input  logic [CNT_W-1:0] dispWidth,
  input  logic             syncActive,
  output hsync_strobe_t    strobe,
  output logic             cfgErr,
  output logic             lineClkOut,
  output logic             hsyncOut
);

  logic [DOT_W-1:0] lineLast;
  logic [DOT_W-1:0] nextDot;
  logic [DOT_W-1:0] startDot;
  logic [DOT_W-1:0] stopDot;
  logic [DOT_W-1:0] reachChars;
  logic [DOT_W-1:0] minPos;
  logic             totalBad;
  logic             posBad;

  // Window limits on the 0-based dot count.
  always_comb begin
    lineLast = ((DOT_W'(lineTotal) + DOT_W'(1)) << CHAR_LOG2) - DOT_W'(1);
    startDot = ((DOT_W'(actPos) + DOT_W'(1)) << CHAR_LOG2) - DOT_W'(1);
    stopDot  = startDot + ((DOT_W'(actWid) + DOT_W'(1)) << CHAR_LOG2);
  end

  always_comb begin
    strobe.lineWrap = (dotCnt >= lineLast);
    nextDot         = strobe.lineWrap ? '0 : dotCnt + DOT_W'(1);
    strobe.syncSet  = !strobe.lineWrap && (nextDot == startDot);
    strobe.syncClr  = strobe.lineWrap || (nextDot == stopDot);
  end

  // Legality of the active setting against the line inputs.
  always_comb begin
    reachChars = DOT_W'(actPos) + DOT_W'(actWid) + DOT_W'(1);
    minPos     = DOT_W'(dispWidth) + DOT_W'(1);
    totalBad   = DOT_W'(lineTotal) < reachChars;
    posBad     = DOT_W'(actPos) < minPos;
    cfgErr     = totalBad || posBad;
  end

  assign hsyncOut   = syncActive && !cfgErr;
  assign lineClkOut = syncActive && !cfgErr;

endmodule

// File: rtl/lcd_hsync_gen.sv
module lcd_hsync_gen
  import lcd_hsync_pkg::*;
#(
  parameter int WID_W     = 4,
  parameter int POS_W     = 8,
  parameter int CNT_W     = 8,
  parameter int CHAR_LOG2 = 3,
  parameter int REG_W     = 16,
  parameter logic [WID_W-1:0] RST_WID = 4'h0,
  parameter logic [POS_W-1:0] RST_POS = 8'h50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic [CNT_W-1:0] lineTotal,
  input  logic [CNT_W-1:0] dispWidth,
  output logic             lineClk,
  output logic             hsync,
  output logic             cfgError
);

  localparam int WIDEST = (CNT_W > POS_W) ? CNT_W : POS_W;
  localparam int DOT_W  = WIDEST + CHAR_LOG2 + 2;

  hsync_strobe_t    strobe;
  logic [WID_W-1:0] actWid;
  logic [POS_W-1:0] actPos;
  logic [DOT_W-1:0] dotCnt;
  logic             syncActive;

  lcd_hsync_dp #(
    .WID_W(WID_W), .POS_W(POS_W), .REG_W(REG_W), .DOT_W(DOT_W),
    .RST_WID(RST_WID), .RST_POS(RST_POS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrData(regWrData),
    .strobe(strobe), .rdData(regRdData), .actWid(actWid), .actPos(actPos),
    .dotCnt(dotCnt), .syncActive(syncActive)
  );

  lcd_hsync_ctl #(
    .WID_W(WID_W), .POS_W(POS_W), .CNT_W(CNT_W),
    .CHAR_LOG2(CHAR_LOG2), .DOT_W(DOT_W)
  ) u_ctl (
    .dotCnt(dotCnt), .actWid(actWid), .actPos(actPos),
    .lineTotal(lineTotal), .dispWidth(dispWidth), .syncActive(syncActive),
    .strobe(strobe), .cfgErr(cfgError), .lineClkOut(lineClk), .hsyncOut(hsync)
  );

endmodule

// File: rtl/lcd_hsync_chk.sv
module lcd_hsync_chk #(
  parameter int WID_W     = 4,
  parameter int POS_W     = 8,
  parameter int CHAR_LOG2 = 3,
  parameter int REG_W     = 16,
  parameter int DOT_W     = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             hsync,
  input logic             lineClk,
  input logic             cfgError,
  input logic [DOT_W-1:0] dotCnt,
  input logic [WID_W-1:0] actWid,
  input logic [POS_W-1:0] actPos,
  input logic             lineWrap
);

  localparam int RSV_W = REG_W - WID_W - POS_W;
  localparam logic [REG_W-1:0] KEEP = {{WID_W{1'b1}}, {RSV_W{1'b0}}, {POS_W{1'b1}}};
  localparam int RUN_W = WID_W + CHAR_LOG2 + 1;

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (hsync) runLen <= runLen + RUN_W'(1);
    else runLen <= '0;
  end

  AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData == ($past(regWrData) & KEEP)));  // R2

  AST_RISE_ON_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsync) |-> (((dotCnt + DOT_W'(1)) & DOT_W'((1 << CHAR_LOG2) - 1)) == '0));  // R3

  AST_WIDTH_RUN: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(hsync) && !cfgError) |-> (runLen == ((RUN_W'(actWid) + RUN_W'(1)) << CHAR_LOG2)));  // R3

  AST_ERR_MUTE: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!hsync && !lineClk));  // R8

  AST_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rstN)
    !lineWrap |=> $stable({actWid, actPos}));  // R9

endmodule

bind lcd_hsync_gen lcd_hsync_chk #(
  .WID_W(WID_W), .POS_W(POS_W), .CHAR_LOG2(CHAR_LOG2), .REG_W(REG_W), .DOT_W(DOT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .hsync(hsync), .lineClk(lineClk), .cfgError(cfgError),
  .dotCnt(dotCnt), .actWid(actWid), .actPos(actPos), .lineWrap(strobe.lineWrap)
);

// File: tb/lcd_hsync_gen_test.sv
module lcd_hsync_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [7:0]  lt = 8'd99;
  logic [7:0]  dw = 8'd79;
  logic [15:0] rd;
  logic        lclk, hs, err;

  int vecs = 0;
  int fails = 0;
  int cyc = 0;
  bit chkOn = 1'b0;
  int defPhase = 0;

  always #5 clk = ~clk;

  lcd_hsync_gen uut (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regWrData(wrData), .regRdData(rd),
    .lineTotal(lt), .dispWidth(dw), .lineClk(lclk), .hsync(hs), .cfgError(err)
  );

  // Bench reference: line position, shadow and active setting, per R2 and R9.
  int          tbDot;
  logic [15:0] mShadow, mAct;

  always @(posedge clk) begin
    if (!rstN) begin
      tbDot   <= 0;
      mShadow <= 16'h0050;
      mAct    <= 16'h0050;
    end else begin
      if (tbDot >= (int'(lt) + 1) * 8 - 1) begin
        tbDot <= 0;
        mAct  <= mShadow;
      end else begin
        tbDot <= tbDot + 1;
      end
      if (wrEn) mShadow <= wrData & 16'hF0FF;
    end
  end

  function automatic bit errModel();
    int p = int'(mAct[7:0]);
    int w = int'(mAct[15:12]);
    return (int'(lt) < p + w + 1) || (p < int'(dw) + 1);
  endfunction

  function automatic bit syncModel();
    int p = int'(mAct[7:0]);
    int w = int'(mAct[15:12]);
    int first = (p + 1) * 8;
    int d1 = tbDot + 1;
    return !errModel() && d1 >= first && d1 < first + (w + 1) * 8;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s dot=%0d actual=%0h expected=%0h", tag, tbDot, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && chkOn) begin
      check(hs == syncModel(), "R3 hsync window", int'(hs), int'(syncModel()));
      check(lclk == hs, "R5 line clock equals hsync", int'(lclk), int'(hs));
      check(err == errModel(), "R6/R7 error flag", int'(err), int'(errModel()));
      check(rd == mShadow, "R2 readback", int'(rd), int'(mShadow));
      if (errModel())
        check(!hs && !lclk, "R8 sync muted on error", int'({hs, lclk}), 0);
      if (defPhase == 1 && (tbDot == 646 || tbDot == 647 || tbDot == 654 || tbDot == 655))
        check(hs == (tbDot == 647 || tbDot == 654), "R4 dots 648..655",
              int'(hs), int'(tbDot == 647 || tbDot == 654));
      if (defPhase == 2 && (tbDot == 654 || tbDot == 655))
        check(hs == (tbDot == 654), "R9 running pulse kept", int'(hs), int'(tbDot == 654));
      if (defPhase == 3 && (tbDot == 726 || tbDot == 727 || tbDot == 758 || tbDot == 759))
        check(hs == (tbDot == 727 || tbDot == 758), "R9 new window next line",
              int'(hs), int'(tbDot == 727 || tbDot == 758));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic waitDot(int n);
    do @(negedge clk); while (tbDot != n);
  endtask

  task automatic regWrite(logic [15:0] v);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic resetWith(logic [7:0] t, logic [7:0] d);
    rstN = 1'b0;
    lt = t;
    dw = d;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runCfg(logic [7:0] t, logic [7:0] d, int w, int p);
    resetWith(t, d);
    repeat (4) @(negedge clk);
    regWrite({4'(w), 4'h0, 8'(p)});
    repeat (3 * (int'(t) + 1) * 8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rd == 16'h0050, "R1 reset value", int'(rd), 16'h0050);
    check(!hs && !lclk, "R1 sync low in reset", int'({hs, lclk}), 0);
    rstN = 1'b1;
    chkOn = 1'b1;
    @(negedge clk);
    regWrite(16'hFFFF);
    check(rd == 16'hF0FF, "R2 reserved bits read zero", int'(rd), 16'hF0FF);

    // Reset setting on a full-size line, then a write in the middle of the pulse.
    resetWith(8'd99, 8'd79);
    defPhase = 1;
    waitDot(651);
    defPhase = 2;
    regWrite(16'h305A);
    waitDot(0);
    defPhase = 3;
    waitDot(760);
    defPhase = 0;

    // Sweep every width against four positions on a 21-character line.
    foreach (posList[i]) begin
      for (int w = 0; w < 16; w++) runCfg(8'd20, 8'd9, w, posList[i]);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  int posList[4] = '{9, 10, 14, 19};

endmodule